// File: doc/BRIEF.md
# Per-Batch Vertex Index Deduplicator

This block sits between index fetch and vertex shading. It takes a stream of vertex indices and packs the distinct ones into shading batches of up to 32 vertices. Every incoming index is looked up in one step against all occupied entries of the current batch's tag array. A repeated index reuses the slot it already holds. A new index takes the next free slot. For every accepted index the block reports the batch number and the slot, in arrival order, so that primitive assembly can later rebuild its primitives from shaded batch results.

A batch closes in one of two ways. A new index may find every slot taken, or the flush input may end a partial batch, for example at the end of a draw. The closed batch is then offered on a dispatch port as a vertex count plus the full tag array, using a valid/ready handshake. Index input stalls until the batch is taken. The next batch starts with every entry empty, so lookups never match across a batch boundary.

The controller has two states. COLLECT takes indices and watches for a closing condition. DISPATCH holds the closed batch on the dispatch port. The transition COLLECT→DISPATCH is taken on a refused miss or on a flush of a non-empty batch. DISPATCH→COLLECT is taken on the dispatch handshake, which clears the tags and advances the batch number. In all other cycles each state holds.

Top module: `vtx_batch_dedup`

## Requirements
- R1: After reset, in_ready is 1 (with flush_req low), out_valid and disp_valid are 0, and the first batch number is 0.
- R2: An accepted index that matches no occupied entry of the current batch is given the lowest free slot, which equals the number of distinct indices the batch held before it, and out_hit is 0.
- R3: An accepted index equal to one already held in the current batch returns that entry's slot with out_hit 1 and takes no new slot. This includes the case where all 32 slots are taken.
- R4: An index is accepted when in_valid and in_ready are both 1 at a rising clock edge. Exactly one cycle later out_valid is 1 for one cycle with out_slot, out_hit and out_batch_id for that index, in input order. In cycles with no acceptance, out_valid is 0 one cycle later.
- R5: When all 32 slots are taken, an index that matches none of them sees in_ready at 0 and closes the batch with a count of 32. Once that batch is dispatched, the same index is accepted as slot 0 of the next batch.
- R6: A new batch starts empty, so an index held in an earlier batch misses again. The batch number rises by one, modulo 256, at each dispatch handshake.
- R7: While flush_req is 1, in_ready is 0. A flush of a batch that holds at least one index closes that batch. A flush of an empty batch has no effect: no dispatch occurs, and the next index gets slot 0 with the same batch number.
- R8: While disp_valid is 1, disp_count gives the number of distinct indices (1 to 32) and disp_batch_id gives the batch number. disp_tags bits [k*32 +: 32] hold the index stored in slot k, and slots at or above the count read as zero. All of these stay unchanged until the handshake.
- R9: While disp_valid is 1, in_ready is 0. The batch is handed over at a rising edge where disp_valid and disp_ready are both 1. After that edge, disp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Index present on in_index |
| in_ready | output | 1 | Index accepted this cycle if in_valid |
| in_index | input | 32 | Vertex index |
| flush_req | input | 1 | Close the current partial batch |
| out_valid | output | 1 | Per-index result valid |
| out_slot | output | 5 | Slot of the accepted index within its batch |
| out_hit | output | 1 | Index was already held in the batch |
| out_batch_id | output | 8 | Batch number of the accepted index |
| disp_valid | output | 1 | Closed batch offered |
| disp_ready | input | 1 | Shading side takes the batch |
| disp_count | output | 6 | Distinct vertices in the batch |
| disp_batch_id | output | 8 | Batch number of the offered batch |
| disp_tags | output | 1024 | Saved tag array, slot k at bits [k*32 +: 32] |

## Verification
The assertions assume a dispatch consumer whose disp_ready may arrive in any cycle. They also assume that flush_req and in_valid are never used to carry an index during a flush. The stimulus drives flush_req only while in_valid is low. It holds disp_ready low for zero to two cycles before raising it. Indices are drawn from a range of only 40 values, so hits, full batches and refused misses all occur often. The directed part covers a hit on a full batch, a flush of an empty batch, and a repeat of an index across a boundary.

// File: rtl/vbd_pkg.sv
package vbd_pkg;
    typedef enum logic [0:0] {
        ST_COLLECT  = 1'b0,
        ST_DISPATCH = 1'b1
    } vbd_state_e;
endpackage

// File: rtl/vbd_tag_store.sv
// Tag registers and occupancy flags for one batch; cleared as a whole.
module vbd_tag_store #(
    parameter int SLOTS  = 32,
    parameter int IDX_W  = 32,
    parameter int SLOT_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [SLOT_W-1:0]        wr_slot,
    input  logic [IDX_W-1:0]         wr_idx,
    output logic [SLOTS*IDX_W-1:0]   tags_flat,
    output logic [SLOTS-1:0]         occ
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_entry
        logic [IDX_W-1:0] tag_q;
        logic             occ_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q <= '0;
                occ_q <= 1'b0;
            end else if (clr) begin
                tag_q <= '0;
                occ_q <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                tag_q <= wr_idx;
                occ_q <= 1'b1;
            end
        end

        assign tags_flat[g*IDX_W +: IDX_W] = tag_q;
        assign occ[g]                      = occ_q;
    end
endmodule

// File: rtl/vbd_tag_match.sv
// Parallel compare of one key against every occupied tag, with slot encode.
module vbd_tag_match #(
    parameter int SLOTS  = 32,
    parameter int IDX_W  = 32,
    parameter int SLOT_W = 5
) (
    input  logic [IDX_W-1:0]         key,
    input  logic [SLOTS*IDX_W-1:0]   tags_flat,
    input  logic [SLOTS-1:0]         occ,
    output logic                     hit,
    output logic [SLOT_W-1:0]        hit_slot
);
    logic [SLOTS-1:0] match;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = occ[g] && (tags_flat[g*IDX_W +: IDX_W] == key);
    end

    always_comb begin
        hit      = |match;
        hit_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/vtx_batch_dedup.sv
// Groups vertex indices into batches of distinct vertices and hands each
// closed batch to a dispatch port.
module vtx_batch_dedup
    import vbd_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int IDX_W = 32,
    parameter int BID_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [IDX_W-1:0]             in_index,
    input  logic                         flush_req,
    output logic                         out_valid,
    output logic [$clog2(SLOTS)-1:0]     out_slot,
    output logic                         out_hit,
    output logic [BID_W-1:0]             out_batch_id,
    output logic                         disp_valid,
    input  logic                         disp_ready,
    output logic [$clog2(SLOTS+1)-1:0]   disp_count,
    output logic [BID_W-1:0]             disp_batch_id,
    output logic [SLOTS*IDX_W-1:0]       disp_tags
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    vbd_state_e          state_q, state_d;
    logic [CNT_W-1:0]    fill_q;
    logic [BID_W-1:0]    bid_q;
    logic                full;
    logic                look_hit;
    logic [SLOT_W-1:0]   look_slot;
    logic                accept;
    logic                alloc;
    logic                close_req;
    logic                disp_fire;
    logic [SLOTS*IDX_W-1:0] tags_flat;
    logic [SLOTS-1:0]    occ;

    vbd_tag_store #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (disp_fire),
        .wr_en     (alloc),
        .wr_slot   (fill_q[SLOT_W-1:0]),
        .wr_idx    (in_index),
        .tags_flat (tags_flat),
        .occ       (occ)
    );

    vbd_tag_match #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_match (
        .key       (in_index),
        .tags_flat (tags_flat),
        .occ       (occ),
        .hit       (look_hit),
        .hit_slot  (look_slot)
    );

    assign full = (fill_q == CNT_W'(SLOTS));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT:  if (close_req) state_d = ST_DISPATCH;
            ST_DISPATCH: if (disp_ready) state_d = ST_COLLECT;
            default:     state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // Handshake and output decode
    always_comb begin
        in_ready      = 1'b0;
        close_req     = 1'b0;
        disp_valid    = 1'b0;
        disp_fire     = 1'b0;
        unique case (state_q)
            ST_COLLECT: begin
                in_ready  = !flush_req && (look_hit || !full);
                close_req = (flush_req && (fill_q != '0)) ||
                            (!flush_req && in_valid && !look_hit && full);
            end
            ST_DISPATCH: begin
                disp_valid = 1'b1;
                disp_fire  = disp_ready;
            end
            default: ;
        endcase
        accept        = in_valid && in_ready;
        alloc         = accept && !look_hit;
        disp_count    = fill_q;
        disp_batch_id = bid_q;
        disp_tags     = tags_flat;
    end

    // Batch fill, batch number and per-index result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q       <= '0;
            bid_q        <= '0;
            out_valid    <= 1'b0;
            out_slot     <= '0;
            out_hit      <= 1'b0;
            out_batch_id <= '0;
        end else begin
            if (disp_fire) begin
                fill_q <= '0;
                bid_q  <= bid_q + 1'b1;
            end else if (alloc) begin
                fill_q <= fill_q + 1'b1;
            end
            out_valid <= accept;
            if (accept) begin
                out_slot     <= look_hit ? look_slot : fill_q[SLOT_W-1:0];
                out_hit      <= look_hit;
                out_batch_id <= bid_q;
            end
        end
    end
endmodule

// File: rtl/vbd_checker.sv
module vbd_checker #(
    parameter int SLOTS = 32,
    parameter int BID_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       flush_req,
    input logic                       out_valid,
    input logic                       disp_valid,
    input logic                       disp_ready,
    input logic [$clog2(SLOTS+1)-1:0] disp_count,
    input logic [BID_W-1:0]           disp_batch_id
);
    a_r9_stall_while_offered: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !in_ready);

    a_r8_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=>
            (disp_valid && $stable(disp_count) && $stable(disp_batch_id)));

    a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_count >= 1 && disp_count <= SLOTS));

    a_r4_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r4_no_result_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);

    a_r9_offer_drops_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> !disp_valid);

    a_r6_bid_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
            ($past(disp_batch_id) + 1'b1 == disp_batch_id));

    a_r7_flush_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !in_ready);
endmodule

bind vtx_batch_dedup vbd_checker #(.SLOTS(SLOTS), .BID_W(BID_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .flush_req     (flush_req),
    .out_valid     (out_valid),
    .disp_valid    (disp_valid),
    .disp_ready    (disp_ready),
    .disp_count    (disp_count),
    .disp_batch_id (disp_batch_id)
);

// File: tb/vtx_batch_dedup_tb.sv
module vtx_batch_dedup_tb;
    localparam int CLK_P = 10;
    localparam int SLOTS = 32;
    localparam int IDX_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [IDX_W-1:0]   in_index = '0;
    logic               flush_req = 1'b0;
    logic               out_valid;
    logic [4:0]         out_slot;
    logic               out_hit;
    logic [7:0]         out_batch_id;
    logic               disp_valid;
    logic               disp_ready = 1'b0;
    logic [5:0]         disp_count;
    logic [7:0]         disp_batch_id;
    logic [SLOTS*IDX_W-1:0] disp_tags;

    int checks = 0;
    int failures = 0;

    logic [IDX_W-1:0] mtag [SLOTS];
    int               mcount = 0;
    logic [7:0]       mbid = '0;

    always #(CLK_P/2) clk = ~clk;

    vtx_batch_dedup u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .flush_req(flush_req), .out_valid(out_valid),
        .out_slot(out_slot), .out_hit(out_hit), .out_batch_id(out_batch_id),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_count(disp_count),
        .disp_batch_id(disp_batch_id), .disp_tags(disp_tags)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_find(input logic [IDX_W-1:0] v,
                                       output bit h, output int s);
        h = 0; s = mcount;
        for (int i = 0; i < mcount; i++) begin
            if (!h && mtag[i] == v) begin h = 1; s = i; end
        end
    endfunction

    function automatic logic [SLOTS*IDX_W-1:0] model_tags();
        logic [SLOTS*IDX_W-1:0] f = '0;
        for (int i = 0; i < mcount; i++) f[i*IDX_W +: IDX_W] = mtag[i];
        return f;
    endfunction

    // Called just after the edge that closed a batch.
    task automatic take_dispatch(input int delay);
        logic [SLOTS*IDX_W-1:0] et;
        for (int w = 0; w < delay; w++) begin
            @(negedge clk); flush_req = 1'b0; #1;
            chk(disp_valid == 1'b1, "R9", "disp_valid while waiting", disp_valid, 1);
            chk(in_ready == 1'b0, "R9", "in_ready stalled", in_ready, 0);
        end
        @(negedge clk); flush_req = 1'b0; disp_ready = 1'b1; #1;
        chk(disp_valid == 1'b1, "R9", "disp_valid at take", disp_valid, 1);
        chk(disp_count == 6'(mcount), "R8", "disp_count", disp_count, mcount);
        chk(disp_batch_id == mbid, "R8", "disp_batch_id", disp_batch_id, mbid);
        et = model_tags();
        checks++;
        if (disp_tags !== et) begin
            failures++;
            $display("FAIL R8 disp_tags actual=%h expected=%h", disp_tags, et);
        end
        @(posedge clk); #1;
        disp_ready = 1'b0;
        mbid = mbid + 1'b1;
        mcount = 0;
        for (int i = 0; i < SLOTS; i++) mtag[i] = '0;
        chk(disp_valid == 1'b0, "R9", "disp_valid after take", disp_valid, 0);
    endtask

    task automatic send_idx(input logic [IDX_W-1:0] v, input int delay);
        bit h; int s;
        @(negedge clk); flush_req = 1'b0; in_valid = 1'b1; in_index = v; #1;
        model_find(v, h, s);
        if (!h && mcount == SLOTS) begin
            chk(in_ready == 1'b0, "R5", "in_ready on full miss", in_ready, 0);
            @(posedge clk); #1;
            take_dispatch(delay);
            model_find(v, h, s);
            chk(s == 0 && !h, "R5", "refused miss restarts at slot", s, 0);
        end
        chk(in_ready == 1'b1, h ? "R3" : "R2", "in_ready", in_ready, 1);
        @(posedge clk); #1;
        chk(out_valid == 1'b1, "R4", "out_valid", out_valid, 1);
        chk(out_slot == 5'(s), h ? "R3" : "R2", "out_slot", out_slot, s);
        chk(out_hit == h, h ? "R3" : "R2", "out_hit", out_hit, h);
        chk(out_batch_id == mbid, "R6", "out_batch_id", out_batch_id, mbid);
        if (!h) begin mtag[mcount] = v; mcount++; end
    endtask

    task automatic idle_cycle();
        @(negedge clk); in_valid = 1'b0; flush_req = 1'b0;
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R4", "out_valid idle", out_valid, 0);
    endtask

    task automatic do_flush(input int delay);
        @(negedge clk); in_valid = 1'b0; flush_req = 1'b1; #1;
        chk(in_ready == 1'b0, "R7", "in_ready during flush", in_ready, 0);
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R4", "out_valid on flush", out_valid, 0);
        if (mcount > 0) begin
            chk(disp_valid == 1'b1, "R7", "flush closes batch", disp_valid, 1);
            take_dispatch(delay);
        end else begin
            chk(disp_valid == 1'b0, "R7", "empty flush ignored", disp_valid, 0);
            @(negedge clk); flush_req = 1'b0;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < SLOTS; i++) mtag[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(disp_valid == 1'b0, "R1", "disp_valid after reset", disp_valid, 0);

        // R7 empty flush has no effect
        do_flush(0);
        send_idx(32'd500, 0);
        chk(out_batch_id == 8'd0, "R7", "batch id after empty flush", out_batch_id, 0);
        send_idx(32'd500, 0);
        idle_cycle();

        // Fill to 32 distinct, hit while full (R3), then refused miss (R5)
        for (int k = 1; k < SLOTS; k++) send_idx(32'(1000 + k), 0);
        send_idx(32'd1005, 0);
        send_idx(32'd500, 0);
        send_idx(32'hDEAD_BEEF, 2);
        // R6 index from the previous batch misses again
        send_idx(32'd1005, 0);
        send_idx(32'hDEAD_BEEF, 0);
        // R7 flush of a partial batch
        do_flush(1);
        send_idx(32'd1005, 0);
        do_flush(0);

        // Random mix
        for (int n = 0; n < 700; n++) begin
            int r = int'($urandom % 100);
            if (r < 3) do_flush(int'($urandom % 3));
            else if (r < 8) idle_cycle();
            else send_idx(32'($urandom % 40), int'($urandom % 3));
        end
        do_flush(0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule